// File: doc/BRIEF.md
# Page Protection Register Bank with Indirect SRAM Test Port

This block is the register file that sits beside a page protection unit. There is one copy for the data side and one for the instruction side. Each side holds a memory control word, fault status and fault address words, a set of page start descriptors and a set of page attribute descriptors, a test command word and a pair of test data words. Software reaches all of them through a simple request/done register bus that accepts only full 32-bit words.

The data-side test command can also move data. Writing a non-zero command builds a scattered address inside the L1 SRAM window from fields of the command. The block then moves 64 bits between the two test data words and that SRAM location over a word-wide memory master port with a request/acknowledge handshake. The bus access that wrote the command is held until both beats have been acknowledged. Commands that use reserved bits, that target the tag array, or that are written to the instruction-side test command do not start a transfer. Each of these raises a one-cycle flag instead.

Top module: `prot_mmr_bank`

## Requirements
- R1: An access whose size code is not 2 (size codes: 0 byte, 1 halfword, 2 word, 3 reserved) completes with `bus_err` set and changes no state. This also applies when the offset is unmapped.
- R2: A word access to an offset that is not word aligned or not mapped completes with `bus_err` set and changes no state.
- R3: Each side (data side at offset 0x0000, instruction side at 0x1000) maps control at +0x004, start descriptor i at +0x100+4i, attribute descriptor i at +0x200+4i and test data words at +0x400 and +0x404. All of these can be written and read back. The data-side test command at 0x300 reads back the last value written to it.
- R4: After reset, offset 0x000 reads 0xFF800000, both control words read 0x00000001, and every other register reads 0.
- R5: Writes to 0x000, 0x008, 0x00C, 0x1000, 0x1008 and 0x100C complete without error and have no effect. 0x1000, 0x1008 and 0x100C read 0, and 0x000 keeps reading the SRAM base.
- R6: A transfer's first SRAM address is 0xFF800000 with these bits taken from the command: command bit 26 goes to address bit 11, bit 24 to bit 21, bit 23 to bit 15, bits 17:16 to bits 13:12, bit 14 to bit 14, and bits 10:3 to bits 10:3. The second beat uses that address plus 4.
- R7: A transfer command with bit 1 set stores test data word 0 to the first address and word 1 to the second.
- R8: A transfer command with bit 1 clear loads the first address into test data word 0 and the second into word 1.
- R9: Writing zero to the test command performs no SRAM access.
- R10: A non-zero command with any bit set under mask 0xFA7CB801 pulses `cmd_undef` for one cycle in the done cycle and performs no SRAM access.
- R11: A non-zero data-side command with bit 2 (data-array select) clear, or any non-zero write to the instruction-side test command at 0x1300, pulses `cmd_unsup` for one cycle in the done cycle and performs no SRAM access. Offset 0x1300 always reads 0.
- R12: A register access completes with a one-cycle `bus_done` one clock after it is accepted. A transfer completes one clock after the second acknowledge. `sram_req`, `sram_addr` and `sram_we` hold steady until the beat is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until `bus_done` |
| bus_we | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 13 | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_done | output | 1 | One-cycle completion |
| bus_err | output | 1 | Access rejected, valid with `bus_done` |
| bus_rdata | output | 32 | Read data, valid with `bus_done` |
| sram_req | output | 1 | SRAM beat request |
| sram_we | output | 1 | SRAM beat is a store |
| sram_addr | output | 32 | SRAM byte address |
| sram_wdata | output | 32 | SRAM store data |
| sram_ack | input | 1 | SRAM beat acknowledge |
| sram_rdata | input | 32 | SRAM load data, valid with `sram_ack` |
| cmd_undef | output | 1 | Reserved command bits used |
| cmd_unsup | output | 1 | Unsupported test command |

## Verification
The bench aims at the scattered address: each command field is toggled on its own, so a design that routes one field to the wrong address bit hits the wrong SRAM word and the logged address differs. It writes every discarded and unmapped location, and sends non-word sizes to mapped offsets, and then reads the whole bank back. A design that lets such a write land, or that checks the offset before the size, would show a changed register. It also sends reserved-bit, tag-array and instruction-side commands. A design that starts a transfer for these is caught by a monitor that flags any SRAM request the bench did not command. A design that swaps the beat order or returns done early would show swapped test data words or a wrong completion cycle.

// File: rtl/pmb_pkg.sv
`timescale 1ns/1ps
package pmb_pkg;

  localparam int unsigned ADDR_W = 13;

  localparam logic [31:0] CMD_RSVD_MASK = 32'hFA7C_B801;
  localparam int unsigned CMD_WR_BIT    = 1;
  localparam int unsigned CMD_ARRAY_BIT = 2;

  typedef enum logic [2:0] {
    K_BASE, K_CTRL, K_FSTAT, K_FADDR, K_DESC_A, K_DESC_P, K_TCMD, K_TDATA
  } pmb_kind_e;

  typedef enum logic [1:0] {B_IDLE, B_WAIT, B_RESP} bus_st_e;
  typedef enum logic [1:0] {T_IDLE, T_BEAT0, T_BEAT1} eng_st_e;

  // Scatter the command fields into the L1 window address.
  function automatic logic [31:0] pmb_sram_addr(input logic [31:0] base,
                                                input logic [31:0] cmd);
    logic [31:0] a;
    a        = base | (cmd & 32'h0000_47F8);
    a[11]    = a[11] | cmd[26];
    a[21]    = a[21] | cmd[24];
    a[15]    = a[15] | cmd[23];
    a[13:12] = a[13:12] | cmd[17:16];
    return a;
  endfunction

endpackage

// File: rtl/pmb_decode.sv
`timescale 1ns/1ps
module pmb_decode
  import pmb_pkg::*;
#(
  parameter int N_DESC = 16,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] off,
  output logic              hit,
  output logic              side,
  output pmb_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  logic [11:0] sub;
  logic [5:0]  word;

  assign sub  = off[11:0];
  assign word = sub[7:2];
  assign side = off[ADDR_W-1];

  always_comb begin
    hit  = 1'b0;
    kind = K_BASE;
    idx  = '0;
    if (off[1:0] == 2'b00) begin
      unique case (sub[11:8])
        4'h0: if (sub[7:4] == 4'h0) begin
          hit = 1'b1;
          case (sub[3:2])
            2'd0:    kind = K_BASE;
            2'd1:    kind = K_CTRL;
            2'd2:    kind = K_FSTAT;
            default: kind = K_FADDR;
          endcase
        end
        4'h1: if (int'(word) < N_DESC) begin
          hit  = 1'b1;
          kind = K_DESC_A;
          idx  = word[IDX_W-1:0];
        end
        4'h2: if (int'(word) < N_DESC) begin
          hit  = 1'b1;
          kind = K_DESC_P;
          idx  = word[IDX_W-1:0];
        end
        4'h3: if (word == 6'd0) begin
          hit  = 1'b1;
          kind = K_TCMD;
        end
        4'h4: if (word[5:1] == 5'd0) begin
          hit  = 1'b1;
          kind = K_TDATA;
          idx  = IDX_W'(word[0]);
        end
        default: hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pmb_side_regs.sv
`timescale 1ns/1ps
module pmb_side_regs
  import pmb_pkg::*;
#(
  parameter int          N_DESC   = 16,
  parameter int          IDX_W    = 4,
  parameter logic [31:0] CTRL_RST = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  pmb_kind_e        kind,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic [1:0]       ld_en,
  input  logic [31:0]      ld_data,
  output logic [31:0]      rd_word,
  output logic [63:0]      td_pair
);

  logic        ctrl_en;
  logic [31:0] ctrl_q;
  logic [31:0] adr_q [N_DESC];
  logic [31:0] atr_q [N_DESC];
  logic [1:0]        td_en;
  logic [1:0][31:0]  td_d;
  logic [1:0][31:0]  td_q;

  assign ctrl_en = wr_en && (kind == K_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= wdata;
  end

  for (genvar i = 0; i < N_DESC; i++) begin : g_desc
    logic a_en, p_en;
    assign a_en = wr_en && (kind == K_DESC_A) && (idx == IDX_W'(i));
    assign p_en = wr_en && (kind == K_DESC_P) && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    adr_q[i] <= '0;
      else if (a_en) adr_q[i] <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    atr_q[i] <= '0;
      else if (p_en) atr_q[i] <= wdata;
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_td
    always_comb begin
      td_en[j] = ld_en[j] || (wr_en && (kind == K_TDATA) && (idx[0] == 1'(j)));
      td_d[j]  = ld_en[j] ? ld_data : wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        td_q[j] <= '0;
      else if (td_en[j]) td_q[j] <= td_d[j];
    end
  end

  always_comb begin
    case (kind)
      K_CTRL:   rd_word = ctrl_q;
      K_DESC_A: rd_word = adr_q[idx];
      K_DESC_P: rd_word = atr_q[idx];
      default:  rd_word = '0;
    endcase
  end

  assign td_pair = {td_q[1], td_q[0]};

endmodule

// File: rtl/pmb_test_engine.sv
`timescale 1ns/1ps
module pmb_test_engine
  import pmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_we,
  input  logic [31:0] start_addr,
  input  logic [63:0] wd_pair,
  input  logic        sram_ack,
  input  logic [31:0] sram_rdata,
  output logic        sram_req,
  output logic        sram_we,
  output logic [31:0] sram_addr,
  output logic [31:0] sram_wdata,
  output logic [1:0]  ld_en,
  output logic [31:0] ld_data,
  output logic        done
);

  eng_st_e     st_q, st_d;
  logic        cap_en;
  logic [31:0] addr_q;
  logic        we_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      T_IDLE:  if (start)    st_d = T_BEAT0;
      T_BEAT0: if (sram_ack) st_d = T_BEAT1;
      T_BEAT1: if (sram_ack) st_d = T_IDLE;
      default:               st_d = T_IDLE;
    endcase
  end

  assign cap_en = start && (st_q == T_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= T_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b0;
    end else if (cap_en) begin
      addr_q <= start_addr;
      we_q   <= start_we;
    end
  end

  assign sram_req   = (st_q != T_IDLE);
  assign sram_we    = we_q;
  assign sram_addr  = addr_q | {29'd0, (st_q == T_BEAT1), 2'b00};
  assign sram_wdata = (st_q == T_BEAT1) ? wd_pair[63:32] : wd_pair[31:0];
  assign ld_en[0]   = (st_q == T_BEAT0) && sram_ack && !we_q;
  assign ld_en[1]   = (st_q == T_BEAT1) && sram_ack && !we_q;
  assign ld_data    = sram_rdata;
  assign done       = (st_q == T_BEAT1) && sram_ack;

endmodule

// File: rtl/prot_mmr_bank.sv
`timescale 1ns/1ps
module prot_mmr_bank
  import pmb_pkg::*;
#(
  parameter int          N_DESC    = 16,
  parameter logic [31:0] SRAM_BASE = 32'hFF80_0000,
  parameter logic [31:0] CTRL_RST  = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_done,
  output logic              bus_err,
  output logic [31:0]       bus_rdata,
  output logic              sram_req,
  output logic              sram_we,
  output logic [31:0]       sram_addr,
  output logic [31:0]       sram_wdata,
  input  logic              sram_ack,
  input  logic [31:0]       sram_rdata,
  output logic              cmd_undef,
  output logic              cmd_unsup
);

  localparam int IDX_W = (N_DESC > 1) ? $clog2(N_DESC) : 1;

  bus_st_e          st_q, st_d;
  logic             dec_hit, dec_side;
  pmb_kind_e        dec_kind;
  logic [IDX_W-1:0] dec_idx;

  logic             accept, acc_ok, wr_ok;
  logic             dcmd_wr, icmd_wr, cmd_nz, cmd_rsvd, cmd_tag;
  logic             eng_start, eng_done;
  logic [1:0]       eng_ld;
  logic [31:0]      eng_ld_data;

  logic [31:0]      dcmd_q;
  logic [31:0]      rd_val, rdata_d, rdata_q;
  logic             err_d, err_q, undef_d, undef_q, unsup_d, unsup_q;

  logic [31:0]      side_rd [2];
  logic [63:0]      side_td [2];

  pmb_decode #(.N_DESC(N_DESC), .IDX_W(IDX_W)) i_decode (
    .off (bus_addr),
    .hit (dec_hit),
    .side(dec_side),
    .kind(dec_kind),
    .idx (dec_idx)
  );

  assign accept  = (st_q == B_IDLE) && bus_req;
  assign acc_ok  = (bus_size == 2'd2) && dec_hit;
  assign wr_ok   = accept && acc_ok && bus_we;
  assign dcmd_wr = wr_ok && !dec_side && (dec_kind == K_TCMD);
  assign icmd_wr = wr_ok &&  dec_side && (dec_kind == K_TCMD);
  assign cmd_nz   = |bus_wdata;
  assign cmd_rsvd = |(bus_wdata & CMD_RSVD_MASK);
  assign cmd_tag  = !bus_wdata[CMD_ARRAY_BIT];
  assign eng_start = dcmd_wr && cmd_nz && !cmd_rsvd && !cmd_tag;

  for (genvar g = 0; g < 2; g++) begin : g_side
    logic       s_wr;
    logic [1:0] s_ld;
    assign s_wr = wr_ok && (dec_side == 1'(g));
    assign s_ld = (g == 0) ? eng_ld : 2'b00;
    pmb_side_regs #(.N_DESC(N_DESC), .IDX_W(IDX_W), .CTRL_RST(CTRL_RST)) i_side (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (s_wr),
      .kind   (dec_kind),
      .idx    (dec_idx),
      .wdata  (bus_wdata),
      .ld_en  (s_ld),
      .ld_data(eng_ld_data),
      .rd_word(side_rd[g]),
      .td_pair(side_td[g])
    );
  end

  pmb_test_engine i_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (eng_start),
    .start_we  (bus_wdata[CMD_WR_BIT]),
    .start_addr(pmb_sram_addr(SRAM_BASE, bus_wdata)),
    .wd_pair   (side_td[0]),
    .sram_ack  (sram_ack),
    .sram_rdata(sram_rdata),
    .sram_req  (sram_req),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .sram_wdata(sram_wdata),
    .ld_en     (eng_ld),
    .ld_data   (eng_ld_data),
    .done      (eng_done)
  );

  // Read mux for the words not held in the side register files.
  always_comb begin
    case (dec_kind)
      K_BASE:  rd_val = dec_side ? 32'd0 : SRAM_BASE;
      K_FSTAT: rd_val = 32'd0;
      K_FADDR: rd_val = 32'd0;
      K_TCMD:  rd_val = dec_side ? 32'd0 : dcmd_q;
      K_TDATA: rd_val = dec_idx[0] ? side_td[dec_side][63:32] : side_td[dec_side][31:0];
      default: rd_val = side_rd[dec_side];
    endcase
  end

  always_comb begin
    st_d    = st_q;
    rdata_d = (acc_ok && !bus_we) ? rd_val : 32'd0;
    err_d   = !acc_ok;
    undef_d = dcmd_wr && cmd_nz && cmd_rsvd;
    unsup_d = (dcmd_wr && cmd_nz && cmd_tag) || (icmd_wr && cmd_nz);
    case (st_q)
      B_IDLE: if (bus_req)  st_d = eng_start ? B_WAIT : B_RESP;
      B_WAIT: if (eng_done) st_d = B_RESP;
      B_RESP:               st_d = B_IDLE;
      default:              st_d = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= B_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      undef_q <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      undef_q <= undef_d;
      unsup_q <= unsup_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcmd_q <= '0;
    else if (dcmd_wr) dcmd_q <= bus_wdata;
  end

  assign bus_done  = (st_q == B_RESP);
  assign bus_err   = err_q;
  assign bus_rdata = rdata_q;
  assign cmd_undef = undef_q;
  assign cmd_unsup = unsup_q;

endmodule

// File: rtl/pmb_chk.sv
`timescale 1ns/1ps
module pmb_chk
  import pmb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              bus_req,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_done,
  input logic              bus_err,
  input logic              sram_req,
  input logic              sram_ack,
  input logic              sram_we,
  input logic [31:0]       sram_addr,
  input logic              cmd_undef
);

  // R1
  size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && bus_req && (bus_size != 2'd2) |=> bus_done && bus_err);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |=> !bus_done);

  // R12
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_req && !sram_ack |=> sram_req && $stable(sram_addr) && $stable(sram_we));

  // R9
  zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && bus_req && bus_we && (bus_size == 2'd2) &&
    (bus_addr == ADDR_W'(12'h300)) && (bus_wdata == 32'd0) |=> !sram_req);

  // R10
  undef_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_undef |-> !sram_req && bus_done);

endmodule

bind prot_mmr_bank pmb_chk i_pmb_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .idle     (st_q == pmb_pkg::B_IDLE),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_size (bus_size),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_done (bus_done),
  .bus_err  (bus_err),
  .sram_req (sram_req),
  .sram_ack (sram_ack),
  .sram_we  (sram_we),
  .sram_addr(sram_addr),
  .cmd_undef(cmd_undef)
);

// File: tb/test_prot_mmr_bank.sv
`timescale 1ns/1ps
module test_prot_mmr_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_done, bus_err;
  logic [31:0] bus_rdata;
  logic        sram_req, sram_we, sram_ack;
  logic [31:0] sram_addr, sram_wdata, sram_rdata;
  logic        cmd_undef, cmd_unsup;

  int checks = 0;
  int fails  = 0;
  bit xfer_ok = 1'b0;

  // Reference model state
  logic [31:0] m_ctrl [2];
  logic [31:0] m_adr  [2][16];
  logic [31:0] m_atr  [2][16];
  logic [31:0] m_td   [2][2];
  logic [31:0] m_dcmd;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] alog [$];
  bit          wlog [$];

  always #4 clk = ~clk;

  prot_mmr_bank i_prot_mmr_bank (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_ack(sram_ack), .sram_rdata(sram_rdata),
    .cmd_undef(cmd_undef), .cmd_unsup(cmd_unsup)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_A5A5);
  endfunction

  // Simple SRAM: acknowledges one cycle after each request.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ack   <= 1'b0;
      sram_rdata <= '0;
    end else begin
      sram_ack <= sram_req && !sram_ack;
      if (sram_req && !sram_ack) begin
        alog.push_back(sram_addr);
        wlog.push_back(sram_we);
        if (sram_we) mem[sram_addr] = sram_wdata;
        else         sram_rdata <= mem_rd(sram_addr);
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // Every cycle: no SRAM request unless the bench commanded a transfer (R9 R10 R11).
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (sram_req && !xfer_ok) begin
        fails++;
        $display("FAIL R9/R10/R11 unexpected sram_req: actual 1 expected 0");
      end
    end
  end

  function automatic bit m_mapped(input logic [12:0] a);
    int o = int'(a[11:0]);
    if (a[1:0] != 2'b00) return 0;
    return (o < 'h10) || (o >= 'h100 && o < 'h140) || (o >= 'h200 && o < 'h240) ||
           (o == 'h300) || (o == 'h400) || (o == 'h404);
  endfunction

  function automatic logic [31:0] m_read(input logic [12:0] a);
    int s = int'(a[12]);
    int o = int'(a[11:0]);
    if (o == 0)                   return (s == 0) ? 32'hFF80_0000 : 32'd0;
    if (o == 4)                   return m_ctrl[s];
    if (o >= 'h100 && o < 'h140)  return m_adr[s][(o - 'h100) / 4];
    if (o >= 'h200 && o < 'h240)  return m_atr[s][(o - 'h200) / 4];
    if (o == 'h300)               return (s == 0) ? m_dcmd : 32'd0;
    if (o == 'h400)               return m_td[s][0];
    if (o == 'h404)               return m_td[s][1];
    return 32'd0;
  endfunction

  task automatic m_write(input logic [12:0] a, input logic [31:0] d);
    int s = int'(a[12]);
    int o = int'(a[11:0]);
    if (o == 4)                        m_ctrl[s] = d;
    else if (o >= 'h100 && o < 'h140)  m_adr[s][(o - 'h100) / 4] = d;
    else if (o >= 'h200 && o < 'h240)  m_atr[s][(o - 'h200) / 4] = d;
    else if (o == 'h300 && s == 0)     m_dcmd = d;
    else if (o == 'h400)               m_td[s][0] = d;
    else if (o == 'h404)               m_td[s][1] = d;
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] c);
    logic [31:0] a;
    a        = 32'hFF80_0000;
    a[11]    = c[26];
    a[21]    = c[24];
    a[15]    = c[23];
    a[13:12] = c[17:16];
    a[14]    = c[14];
    a[10:3]  = c[10:3];
    return a;
  endfunction

  task automatic bus_xfer(input bit we, input logic [1:0] sz, input logic [12:0] a,
                          input logic [31:0] wd, output logic [31:0] rd, output bit er,
                          output bit fu, output bit fs, output int cyc);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bus_done && cyc < 100);
    rd = bus_rdata; er = bus_err; fu = cmd_undef; fs = cmd_unsup;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  // Register write with model update; expects no error and one-cycle completion.
  task automatic wr(input string r, input logic [12:0] a, input logic [31:0] d);
    logic [31:0] rd; bit er, fu, fs; int cyc;
    bus_xfer(1'b1, 2'd2, a, d, rd, er, fu, fs, cyc);
    chk(r, {31'd0, er}, 32'd0);
    chk("R12", cyc, 1);
    if (m_mapped(a)) m_write(a, d);
  endtask

  task automatic rd_chk(input string r, input logic [12:0] a);
    logic [31:0] rd; bit er, fu, fs; int cyc;
    bus_xfer(1'b0, 2'd2, a, 32'd0, rd, er, fu, fs, cyc);
    chk(r, {31'd0, er}, 32'd0);
    chk(r, rd, m_read(a));
  endtask

  task automatic err_chk(input string r, input bit we, input logic [1:0] sz, input logic [12:0] a);
    logic [31:0] rd; bit er, fu, fs; int cyc;
    bus_xfer(we, sz, a, 32'hDEAD_BEEF, rd, er, fu, fs, cyc);
    chk(r, {31'd0, er}, 32'd1);
    chk(r, cyc, 1);
  endtask

  task automatic readback_all(input string r);
    for (int s = 0; s < 2; s++) begin
      logic [12:0] b = 13'(s * 'h1000);
      rd_chk(r, b);
      rd_chk(r, b + 13'h004);
      rd_chk(r, b + 13'h008);
      rd_chk(r, b + 13'h00C);
      rd_chk(r, b + 13'h300);
      rd_chk(r, b + 13'h400);
      rd_chk(r, b + 13'h404);
      for (int i = 0; i < 16; i++) begin
        rd_chk(r, b + 13'h100 + 13'(4 * i));
        rd_chk(r, b + 13'h200 + 13'(4 * i));
      end
    end
  endtask

  // Issue a command expected to transfer; check addresses, direction and timing.
  task automatic xfer_cmd(input string r, input logic [31:0] c);
    logic [31:0] rd; bit er, fu, fs; int cyc;
    logic [31:0] ea;
    ea = exp_addr(c);
    alog.delete(); wlog.delete();
    xfer_ok = 1'b1;
    bus_xfer(1'b1, 2'd2, 13'h300, c, rd, er, fu, fs, cyc);
    xfer_ok = 1'b0;
    m_dcmd = c;
    chk(r, {31'd0, er}, 32'd0);
    chk("R12", cyc, 5);
    chk(r, alog.size(), 2);
    if (alog.size() == 2) begin
      chk("R6", alog[0], ea);
      chk("R6", alog[1], ea + 32'd4);
      chk(r, {31'd0, wlog[0]}, {31'd0, c[1]});
    end
    chk(r, {30'd0, fu, fs}, 32'd0);
    if (c[1]) begin
      chk("R7", mem_rd(ea), m_td[0][0]);
      chk("R7", mem_rd(ea + 32'd4), m_td[0][1]);
    end else begin
      m_td[0][0] = mem_rd(ea);
      m_td[0][1] = mem_rd(ea + 32'd4);
    end
  endtask

  // Command that must not transfer; checks the flags.
  task automatic flag_cmd(input string r, input logic [12:0] a, input logic [31:0] c,
                          input bit eu, input bit es);
    logic [31:0] rd; bit er, fu, fs; int cyc;
    bus_xfer(1'b1, 2'd2, a, c, rd, er, fu, fs, cyc);
    m_write(a, c);
    chk(r, {31'd0, er}, 32'd0);
    chk(r, cyc, 1);
    chk(r, {31'd0, fu}, {31'd0, eu});
    chk(r, {31'd0, fs}, {31'd0, es});
    @(negedge clk);
    chk("R12", {30'd0, cmd_undef, cmd_unsup}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'd2;
    bus_addr = '0; bus_wdata = '0;
    for (int s = 0; s < 2; s++) begin
      m_ctrl[s] = 32'h1;
      m_td[s][0] = '0; m_td[s][1] = '0;
      for (int i = 0; i < 16; i++) begin m_adr[s][i] = '0; m_atr[s][i] = '0; end
    end
    m_dcmd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    chk("R4", {31'd0, bus_done}, 32'd0);
    chk("R4", {31'd0, sram_req}, 32'd0);
    readback_all("R4");

    // R3: every register of both sides
    for (int s = 0; s < 2; s++) begin
      logic [12:0] b = 13'(s * 'h1000);
      wr("R3", b + 13'h004, 32'hC0DE_0000 + 32'(s));
      wr("R3", b + 13'h400, 32'h1111_0000 + 32'(s));
      wr("R3", b + 13'h404, 32'h2222_0000 + 32'(s));
      for (int i = 0; i < 16; i++) begin
        wr("R3", b + 13'h100 + 13'(4 * i), 32'h0010_0000 * 32'(i + 1) + 32'(s));
        wr("R3", b + 13'h200 + 13'(4 * i), ~(32'h0000_0100 * 32'(i + 3)) ^ 32'(s));
      end
    end
    readback_all("R3");

    // R5: discarded writes
    wr("R5", 13'h000, 32'hFFFF_FFFF);
    wr("R5", 13'h008, 32'hFFFF_FFFF);
    wr("R5", 13'h00C, 32'hFFFF_FFFF);
    wr("R5", 13'h1000, 32'hFFFF_FFFF);
    wr("R5", 13'h1008, 32'hFFFF_FFFF);
    wr("R5", 13'h100C, 32'hFFFF_FFFF);
    readback_all("R5");

    // R1: non-word sizes rejected, including on unmapped offsets
    err_chk("R1", 1'b1, 2'd0, 13'h104);
    err_chk("R1", 1'b1, 2'd1, 13'h1004);
    err_chk("R1", 1'b1, 2'd3, 13'h400);
    err_chk("R1", 1'b0, 2'd0, 13'h000);
    err_chk("R1", 1'b1, 2'd1, 13'h050);
    err_chk("R1", 1'b1, 2'd0, 13'h300);
    readback_all("R1");

    // R2: unmapped and misaligned offsets rejected
    err_chk("R2", 1'b1, 2'd2, 13'h050);
    err_chk("R2", 1'b1, 2'd2, 13'h140);
    err_chk("R2", 1'b1, 2'd2, 13'h304);
    err_chk("R2", 1'b1, 2'd2, 13'h408);
    err_chk("R2", 1'b1, 2'd2, 13'h102);
    err_chk("R2", 1'b1, 2'd2, 13'h1500);
    err_chk("R2", 1'b0, 2'd2, 13'h0800);
    err_chk("R2", 1'b0, 2'd2, 13'h1201);
    readback_all("R2");

    // R9: zero command, no access
    flag_cmd("R9", 13'h300, 32'd0, 1'b0, 1'b0);
    rd_chk("R9", 13'h300);

    // R7: store both words
    wr("R7", 13'h400, 32'hA1B2_C3D4);
    wr("R7", 13'h404, 32'h5566_7788);
    xfer_cmd("R7", (32'h1 << 26) | (32'h1 << 24) | (32'h1 << 23) | (32'h2 << 16) |
                   (32'h1 << 14) | (32'hA5 << 3) | 32'h6);
    rd_chk("R3", 13'h300);

    // R8: load back from the same spot after clobbering the data words
    wr("R8", 13'h400, 32'h0);
    wr("R8", 13'h404, 32'h0);
    xfer_cmd("R8", (32'h1 << 26) | (32'h1 << 24) | (32'h1 << 23) | (32'h2 << 16) |
                   (32'h1 << 14) | (32'hA5 << 3) | 32'h4);
    rd_chk("R8", 13'h400);
    rd_chk("R8", 13'h404);

    // R6: each field on its own
    xfer_cmd("R6", 32'h0400_0004);
    rd_chk("R8", 13'h400);
    xfer_cmd("R6", 32'h0100_0004);
    xfer_cmd("R6", 32'h0080_0004);
    xfer_cmd("R6", 32'h0001_0004);
    xfer_cmd("R6", 32'h0003_0004);
    xfer_cmd("R6", 32'h0000_4004);
    xfer_cmd("R6", 32'h0000_07FC);
    rd_chk("R8", 13'h404);

    // R10: reserved bits
    flag_cmd("R10", 13'h300, 32'h0000_0005, 1'b1, 1'b0);
    flag_cmd("R10", 13'h300, 32'h8000_0004, 1'b1, 1'b0);
    flag_cmd("R10", 13'h300, 32'h0000_0806, 1'b1, 1'b0);
    rd_chk("R10", 13'h400);
    rd_chk("R10", 13'h404);

    // R11: tag array and instruction-side command
    flag_cmd("R11", 13'h300, 32'h0000_0008, 1'b0, 1'b1);
    flag_cmd("R11", 13'h1300, 32'h0000_0006, 1'b0, 1'b1);
    rd_chk("R11", 13'h1300);
    flag_cmd("R11", 13'h1300, 32'h0, 1'b0, 1'b0);
    readback_all("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule